// File: doc/BRIEF.md
# Anode Wire-Group Track Candidate Finder

The block looks for muon tracks crossing a six-layer wire chamber. On every bunch-crossing clock with the strobe `hit_valid` high, it receives one hit vector per layer, each `NWG` wire groups wide. It treats each wire group of layer 2 (the third layer) as a key. Around every key it lays a fixed, lopsided collision-track window that widens towards the outer layers. It counts how many layers have at least one hit inside that window and turns the count into a two-bit quality.

From all keys the block reports two candidates, each as a key index, a quality and a valid flag. The first candidate is the strongest key. The second is the strongest key that lies clear of the first. Both records are registered and appear a fixed two clocks after the strobe.

Top module: `anode_pattern_finder`

## Requirements
- R1: For key k the window spans wire groups k-2..k on layer 0, k-1..k on layer 1, k on layer 2, k..k+1 on layer 3, and k..k+2 on layers 4 and 5. A layer counts once if any hit falls in its span.
- R2: Window positions below 0 or above NWG-1 count as empty, so keys at both ends of the chamber are evaluated with only their in-range positions.
- R3: Quality is 3 when all six layers are hit, 2 for five layers, 1 for four layers and 0 for three layers or fewer.
- R4: The first candidate is the key with the highest quality. Among keys of equal quality, the lowest key index wins.
- R5: The second candidate is the highest-quality key whose index differs from the first candidate's by at least 3. Among keys of equal quality, the lowest index wins.
- R6: A candidate is valid only when its quality is at least 1. An invalid candidate reports key 0 and quality 0, and the second is never valid without the first.
- R7: The candidate records reflect the hits presented with `hit_valid` exactly two clocks earlier. A cycle with `hit_valid` low produces two invalid records, whatever hits are present.
- R8: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bunch-crossing clock |
| rst_n | input | 1 | active-low synchronous reset |
| hit_valid | input | 1 | the hit vectors of this cycle are to be scanned |
| hits_l0 | input | NWG | layer 0 wire-group hits |
| hits_l1 | input | NWG | layer 1 wire-group hits |
| hits_l2 | input | NWG | layer 2 (key layer) wire-group hits |
| hits_l3 | input | NWG | layer 3 wire-group hits |
| hits_l4 | input | NWG | layer 4 wire-group hits |
| hits_l5 | input | NWG | layer 5 wire-group hits |
| c0_valid | output | 1 | first candidate present |
| c0_key | output | $clog2(NWG) | first candidate key wire group |
| c0_qual | output | 2 | first candidate quality |
| c1_valid | output | 1 | second candidate present |
| c1_key | output | $clog2(NWG) | second candidate key wire group |
| c1_qual | output | 2 | second candidate quality |

## Verification
The hardest case to reach is the second-candidate exclusion. A strong track must shadow neighbouring keys that score almost as well as it does, while a weaker track further away has to be picked instead. Directed patterns therefore place two tracks two wire groups apart, and then three apart, with chosen layer counts. Equal-quality pairs probe the tie rule. Tracks clipped at wire group 0 and at the last wire group test the out-of-range padding. A long run of sparse random hits then builds overlapping windows that no directed pattern covers. Every cycle is compared with a behavioural model.

// File: rtl/anode_pattern_finder.sv
module anode_pattern_finder #(
  parameter int NWG = 16,
  localparam int KW = $clog2(NWG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit_valid,
  input  logic [NWG-1:0] hits_l0,
  input  logic [NWG-1:0] hits_l1,
  input  logic [NWG-1:0] hits_l2,
  input  logic [NWG-1:0] hits_l3,
  input  logic [NWG-1:0] hits_l4,
  input  logic [NWG-1:0] hits_l5,
  output logic           c0_valid,
  output logic [KW-1:0]  c0_key,
  output logic [1:0]     c0_qual,
  output logic           c1_valid,
  output logic [KW-1:0]  c1_key,
  output logic [1:0]     c1_qual
);

  logic [NWG+3:0] p0, p1, p2, p3, p4, p5;
  assign p0 = {2'b00, hits_l0, 2'b00};
  assign p1 = {2'b00, hits_l1, 2'b00};
  assign p2 = {2'b00, hits_l2, 2'b00};
  assign p3 = {2'b00, hits_l3, 2'b00};
  assign p4 = {2'b00, hits_l4, 2'b00};
  assign p5 = {2'b00, hits_l5, 2'b00};

  logic [2*NWG-1:0] qv, q_r;
  logic             v1;

  for (genvar k = 0; k < NWG; k++) begin : g_key
    logic [5:0] lh;
    logic [2:0] cnt;
    assign lh[0] = |p0[k+2 -: 3];
    assign lh[1] = |p1[k+2 -: 2];
    assign lh[2] = p2[k+2];
    assign lh[3] = |p3[k+3 -: 2];
    assign lh[4] = |p4[k+4 -: 3];
    assign lh[5] = |p5[k+4 -: 3];
    assign cnt = {2'b0, lh[0]} + {2'b0, lh[1]} + {2'b0, lh[2]}
               + {2'b0, lh[3]} + {2'b0, lh[4]} + {2'b0, lh[5]};
    assign qv[2*k +: 2] = (cnt == 3'd6) ? 2'd3 :
                          (cnt == 3'd5) ? 2'd2 :
                          (cnt == 3'd4) ? 2'd1 : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1  <= 1'b0;
      q_r <= '0;
    end else begin
      v1  <= hit_valid;
      q_r <= hit_valid ? qv : '0;
    end
  end

  logic [KW-1:0] b0, b1;
  logic [1:0]    bq0, bq1;
  logic          f1;

  always_comb begin
    b0  = '0;
    bq0 = q_r[1:0];
    for (int k = 1; k < NWG; k++)
      if (q_r[2*k +: 2] > bq0) begin
        b0  = KW'(k);
        bq0 = q_r[2*k +: 2];
      end
    b1  = '0;
    bq1 = 2'd0;
    f1  = 1'b0;
    for (int k = 0; k < NWG; k++)
      if ((k >= int'(b0) + 3 || int'(b0) >= k + 3) && (!f1 || q_r[2*k +: 2] > bq1)) begin
        b1  = KW'(k);
        bq1 = q_r[2*k +: 2];
        f1  = 1'b1;
      end
  end

  logic e0, e1;
  assign e0 = v1 && (bq0 != 2'd0);
  assign e1 = e0 && f1 && (bq1 != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0_valid <= 1'b0;
      c0_key   <= '0;
      c0_qual  <= 2'd0;
      c1_valid <= 1'b0;
      c1_key   <= '0;
      c1_qual  <= 2'd0;
    end else begin
      c0_valid <= e0;
      c0_key   <= e0 ? b0 : '0;
      c0_qual  <= e0 ? bq0 : 2'd0;
      c1_valid <= e1;
      c1_key   <= e1 ? b1 : '0;
      c1_qual  <= e1 ? bq1 : 2'd0;
    end
  end

endmodule

// File: rtl/anode_pattern_finder_checks.sv
module anode_pattern_finder_checks #(
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_valid,
  input logic          c0_valid,
  input logic [KW-1:0] c0_key,
  input logic [1:0]    c0_qual,
  input logic          c1_valid,
  input logic [KW-1:0] c1_key,
  input logic [1:0]    c1_qual
);

  // R6
  c1_needs_c0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c1_valid |-> c0_valid);

  // R6
  c0_qual_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c0_valid |-> c0_qual != 2'd0);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c0_valid |-> (c0_key == '0 && c0_qual == 2'd0 && !c1_valid));

  // R5
  c1_separation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c1_valid |-> (int'(c1_key) >= int'(c0_key) + 3 || int'(c0_key) >= int'(c1_key) + 3));

  // R4
  c1_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c1_valid |-> c1_qual <= c0_qual);

  // R4
  tie_low_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_valid && c1_qual == c0_qual) |-> c1_key > c0_key);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c0_valid |-> $past(hit_valid, 2));

endmodule

bind anode_pattern_finder anode_pattern_finder_checks #(.KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid),
  .c0_valid(c0_valid), .c0_key(c0_key), .c0_qual(c0_qual),
  .c1_valid(c1_valid), .c1_key(c1_key), .c1_qual(c1_qual)
);

// File: tb/tb_anode_pattern_finder.sv
module tb_anode_pattern_finder;
  localparam int N  = 16;
  localparam int KW = $clog2(N);
  localparam int RW = 2 * (KW + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv = 1'b0;
  logic [N-1:0] h [6];
  logic [N-1:0] nh [6];
  logic nv;
  logic c0_valid, c1_valid;
  logic [KW-1:0] c0_key, c1_key;
  logic [1:0] c0_qual, c1_qual;

  int checks = 0;
  int errors = 0;
  string tag = "R8";
  logic [RW-1:0] pipe0 = '0, pipe1 = '0;

  always #5 clk = ~clk;

  anode_pattern_finder #(.NWG(N)) dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hv),
    .hits_l0(h[0]), .hits_l1(h[1]), .hits_l2(h[2]),
    .hits_l3(h[3]), .hits_l4(h[4]), .hits_l5(h[5]),
    .c0_valid(c0_valid), .c0_key(c0_key), .c0_qual(c0_qual),
    .c1_valid(c1_valid), .c1_key(c1_key), .c1_qual(c1_qual)
  );

  function automatic bit layer_hit(int l, int k);
    int lo, hi;
    case (l)
      0: begin lo = -2; hi = 0; end
      1: begin lo = -1; hi = 0; end
      2: begin lo = 0;  hi = 0; end
      3: begin lo = 0;  hi = 1; end
      default: begin lo = 0; hi = 2; end
    endcase
    for (int o = lo; o <= hi; o++)
      if (k + o >= 0 && k + o < N && h[l][k+o]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [RW-1:0] model();
    int qual [N];
    int first, second;
    logic [KW+2:0] r0, r1;
    for (int k = 0; k < N; k++) begin
      int n = 0;
      for (int l = 0; l < 6; l++) n += int'(layer_hit(l, k));
      qual[k] = (n >= 4) ? n - 3 : 0;
    end
    first = -1;
    second = -1;
    if (hv)
      for (int q = 3; q >= 1 && first < 0; q--)
        for (int k = 0; k < N && first < 0; k++)
          if (qual[k] == q) first = k;
    if (first >= 0)
      for (int q = 3; q >= 1 && second < 0; q--)
        for (int k = 0; k < N && second < 0; k++)
          if (qual[k] == q && (k - first >= 3 || first - k >= 3)) second = k;
    r0 = (first  >= 0) ? {1'b1, KW'(first),  2'(qual[first])}  : '0;
    r1 = (second >= 0) ? {1'b1, KW'(second), 2'(qual[second])} : '0;
    return {r0, r1};
  endfunction

  task automatic clear_hits();
    for (int l = 0; l < 6; l++) nh[l] = '0;
  endtask

  task automatic put(int k, logic [5:0] layers);
    for (int l = 0; l < 6; l++) if (layers[l]) nh[l][k] = 1'b1;
  endtask

  task automatic step();
    logic [RW-1:0] got;
    @(negedge clk);
    got = {c0_valid, c0_key, c0_qual, c1_valid, c1_key, c1_qual};
    checks++;
    if (got !== pipe1) begin
      errors++;
      $display("FAIL %s: outputs actual %h expected %h", tag, got, pipe1);
    end
    pipe1 = pipe0;
    for (int l = 0; l < 6; l++) h[l] = nh[l];
    hv = nv;
    pipe0 = rst_n ? model() : '0;
  endtask

  task automatic shot(string t);
    tag = t;
    nv = 1'b1;
    step();
    clear_hits();
    nv = 1'b0;
    step();
    step();
  endtask

  initial begin
    for (int l = 0; l < 6; l++) h[l] = '0;
    clear_hits();
    nv = 1'b0;
    tag = "R8";
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    pipe0 = '0;
    step();
    // R1: every layer hit at the edge of its span around key 5
    nh[0][3] = 1; nh[1][4] = 1; nh[2][5] = 1; nh[3][6] = 1; nh[4][7] = 1; nh[5][7] = 1;
    shot("R1");
    // R1: layer 0 one beyond its span
    nh[0][2] = 1; nh[1][4] = 1; nh[2][5] = 1; nh[3][6] = 1; nh[4][7] = 1; nh[5][7] = 1;
    shot("R1");
    // R2: tracks clipped at both ends
    put(0, 6'b111111);
    shot("R2");
    put(N-1, 6'b111111);
    shot("R2");
    nh[0][0] = 1; nh[1][0] = 1; nh[2][0] = 1; put(N-1, 6'b111000);
    shot("R2");
    // R3: five, four and three layers
    put(8, 6'b111011);
    shot("R3");
    put(8, 6'b110110);
    shot("R3");
    put(8, 6'b010101);
    shot("R3");
    // R4: equal-quality tie and stronger later key
    put(4, 6'b111111); put(11, 6'b111111);
    shot("R4");
    put(2, 6'b011110); put(12, 6'b111101);
    shot("R4");
    // R5: neighbour two away excluded, three away accepted
    put(6, 6'b111111); put(8, 6'b111111); put(13, 6'b001111);
    shot("R5");
    put(6, 6'b111111); put(9, 6'b011111);
    shot("R5");
    put(9, 6'b111111); put(6, 6'b111101); put(3, 6'b111101);
    shot("R5");
    // R6: nothing, and a lone track
    shot("R6");
    put(7, 6'b111110);
    shot("R6");
    // R7: hits ignored with strobe low, back-to-back strobes
    tag = "R7";
    put(5, 6'b111111); nv = 1'b0;
    step(); step(); step();
    clear_hits();
    for (int i = 0; i < 6; i++) begin
      clear_hits();
      put(i * 2, 6'b111111);
      nv = 1'b1;
      step();
    end
    nv = 1'b0; clear_hits();
    step(); step();
    // R4/R5 random sparse patterns
    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      for (int l = 0; l < 6; l++) nh[l] = N'($urandom & $urandom);
      nv = ($urandom % 4) != 0;
      step();
    end
    nv = 1'b0; clear_hits();
    step(); step(); step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule